// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block produces the DMA request lines for a two-FIFO bridge that joins a 16550-style host port to a local microprocessor port. The FIFOs, the delay timers and the DMA controllers live elsewhere. Only their status flags reach this block, and it turns those flags into four registered request outputs.

On the host side there are two requests, receive and transmit. They follow one of two policies, chosen by the DMA-mode bit of the FIFO control register. In single-transfer mode the receive request is up whenever any character is waiting, and the transmit request is up only when the transmit FIFO is drained. In multi-transfer mode the receive request has hysteresis: it rises when the fill count reaches a programmable trigger level and falls only when the FIFO empties. The transmit request is then up whenever the transmit FIFO has room.

On the processor side there are also two requests. The outbound request moves data from the processor into the processor-to-host FIFO and is raised while that FIFO is not full. The inbound request moves data out of the host-to-processor FIFO and is raised while that FIFO holds data. When delay timers are enabled, both requests use the shadow copies of the flags instead of the live ones. Each processor request can be a level or a one-cycle pulse.

Top module: `uart_dma_req_gen`

## Requirements
- R1: While reset is asserted, all four request outputs are 0, whatever the inputs.
- R2: `dma_multi_i` is the FIFO control register DMA-mode bit (bit 3): 0 selects single-transfer and 1 selects multi-transfer. `rx_trig_i` is the trigger field (bits 7:6), encoded 00 = 1, 01 = 4, 10 = 8 and 11 = 14 characters.
- R3: In single-transfer mode, `host_rx_req_o` is 1 exactly when `rx_count_i` is nonzero.
- R4: In single-transfer mode, `host_tx_req_o` equals `tx_empty_i`.
- R5: In multi-transfer mode, `host_rx_req_o` becomes 1 once `rx_count_i` is at or above the trigger level. It stays 1 at any nonzero count and becomes 0 when the count is 0.
- R6: In multi-transfer mode, `host_tx_req_o` equals the inverse of `tx_full_i`.
- R7: Any cycle spent in single-transfer mode clears the multi-transfer receive hold. After returning to multi-transfer mode with a count below the trigger level, the receive request is therefore 0.
- R8: With `delay_en_i` = 0 and level mode, `cpu_out_req_o` is the inverse of `p2h_full_i` and `cpu_in_req_o` is the inverse of `h2p_empty_i`.
- R9: With `delay_en_i` = 1, the processor requests are taken from `p2h_full_shadow_i` and `h2p_empty_shadow_i`. The live flags then have no effect.
- R10: With an edge-select input at 1, the matching processor request is a single-cycle pulse on each 0-to-1 transition of its condition. The condition history is 0 after reset.
- R11: Every output changes exactly one clock after the input change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dma_multi_i | input | 1 | DMA-mode bit: 1 = multi-transfer |
| rx_trig_i | input | 2 | Receive trigger-level code |
| rx_count_i | input | CNT_W (5) | Host receive FIFO fill count |
| tx_empty_i | input | 1 | Host transmit FIFO empty |
| tx_full_i | input | 1 | Host transmit FIFO full |
| p2h_full_i | input | 1 | Processor-to-host FIFO full, live |
| p2h_full_shadow_i | input | 1 | Processor-to-host FIFO full, delayed copy |
| h2p_empty_i | input | 1 | Host-to-processor FIFO empty, live |
| h2p_empty_shadow_i | input | 1 | Host-to-processor FIFO empty, delayed copy |
| delay_en_i | input | 1 | Use delayed flag copies |
| out_edge_i | input | 1 | Outbound request as pulse (1) or level (0) |
| in_edge_i | input | 1 | Inbound request as pulse (1) or level (0) |
| host_rx_req_o | output | 1 | Host receive DMA request |
| host_tx_req_o | output | 1 | Host transmit DMA request |
| cpu_out_req_o | output | 1 | Processor outbound DMA request |
| cpu_in_req_o | output | 1 | Processor inbound DMA request |

## Verification
Each trigger code is run through the same receive fill sequence: empty, one below the level, at the level, drained back to one, then empty. This separates a correct threshold from an off-by-one one and shows whether the request holds between the set and clear points. The single-transfer runs use counts of 0, 1 and full, which separates the any-data rule from the threshold rule. A multi, single, multi excursion at a mid-range count shows whether the hold is cleared. On the processor side, the live and shadow flags are driven to opposite values so that the selected source is visible. An edge-mode run keeps the condition high for several cycles to confirm that only one pulse appears.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

    // Host receive request state: hysteresis hold and registered request.
    typedef struct packed {
        logic hold;
        logic req;
    } rx_state_t;

    // Processor-side channel state: condition history and registered request.
    typedef struct packed {
        logic cond_prev;
        logic req;
    } cpu_state_t;

    // Trigger-level selector codes.
    typedef enum logic [1:0] {
        TRIG_SEL_A = 2'b00,
        TRIG_SEL_B = 2'b01,
        TRIG_SEL_C = 2'b10,
        TRIG_SEL_D = 2'b11
    } trig_sel_e;

endpackage

// File: rtl/dma_host_rx.sv
module dma_host_rx
    import uart_dma_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TRIG_A   = 1,
    parameter int TRIG_B   = 4,
    parameter int TRIG_C   = 8,
    parameter int TRIG_D   = 14,
    localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             multi_i,
    input  logic [1:0]       trig_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             req_o
);

    rx_state_t        st_d, st_q;
    logic [CNT_W-1:0] level_w;
    logic             nonempty_w;

    always_comb begin
        case (trig_sel_e'(trig_i))
            TRIG_SEL_A: level_w = CNT_W'(TRIG_A);
            TRIG_SEL_B: level_w = CNT_W'(TRIG_B);
            TRIG_SEL_C: level_w = CNT_W'(TRIG_C);
            default:    level_w = CNT_W'(TRIG_D);
        endcase
    end

    assign nonempty_w = (count_i != '0);

    always_comb begin
        st_d = st_q;
        if (!multi_i) begin
            st_d.hold = 1'b0;
            st_d.req  = nonempty_w;
        end else begin
            if (!nonempty_w) begin
                st_d.hold = 1'b0;
            end else if (count_i >= level_w) begin
                st_d.hold = 1'b1;
            end
            st_d.req = st_d.hold;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;

endmodule

// File: rtl/dma_host_tx.sv
module dma_host_tx (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic multi_i,
    input  logic empty_i,
    input  logic full_i,
    output logic req_o
);

    logic req_d, req_q;

    always_comb begin
        req_d = multi_i ? ~full_i : empty_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req_o = req_q;

endmodule

// File: rtl/dma_cpu_req.sv
module dma_cpu_req
    import uart_dma_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic flag_i,
    input  logic shadow_i,
    input  logic delay_en_i,
    input  logic edge_mode_i,
    output logic req_o
);

    cpu_state_t st_d, st_q;
    logic       cond_w;

    // Request condition is the absence of the blocking flag (full or empty).
    assign cond_w = ~(delay_en_i ? shadow_i : flag_i);

    always_comb begin
        st_d           = st_q;
        st_d.cond_prev = cond_w;
        st_d.req       = edge_mode_i ? (cond_w & ~st_q.cond_prev) : cond_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;

endmodule

// File: rtl/uart_dma_req_gen.sv
module uart_dma_req_gen
    import uart_dma_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TRIG_A   = 1,
    parameter int TRIG_B   = 4,
    parameter int TRIG_C   = 8,
    parameter int TRIG_D   = 14,
    localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dma_multi_i,
    input  logic [1:0]       rx_trig_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic             tx_empty_i,
    input  logic             tx_full_i,
    input  logic             p2h_full_i,
    input  logic             p2h_full_shadow_i,
    input  logic             h2p_empty_i,
    input  logic             h2p_empty_shadow_i,
    input  logic             delay_en_i,
    input  logic             out_edge_i,
    input  logic             in_edge_i,
    output logic             host_rx_req_o,
    output logic             host_tx_req_o,
    output logic             cpu_out_req_o,
    output logic             cpu_in_req_o
);

    localparam int NUM_CPU_CH = 2;

    logic [NUM_CPU_CH-1:0] live_w, shad_w, edge_w, req_w;

    dma_host_rx #(
        .RX_DEPTH (RX_DEPTH),
        .TRIG_A   (TRIG_A),
        .TRIG_B   (TRIG_B),
        .TRIG_C   (TRIG_C),
        .TRIG_D   (TRIG_D)
    ) u_host_rx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .multi_i (dma_multi_i),
        .trig_i  (rx_trig_i),
        .count_i (rx_count_i),
        .req_o   (host_rx_req_o)
    );

    dma_host_tx u_host_tx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .multi_i (dma_multi_i),
        .empty_i (tx_empty_i),
        .full_i  (tx_full_i),
        .req_o   (host_tx_req_o)
    );

    // Channel 0: outbound (blocked by full); channel 1: inbound (blocked by empty).
    assign live_w = {h2p_empty_i, p2h_full_i};
    assign shad_w = {h2p_empty_shadow_i, p2h_full_shadow_i};
    assign edge_w = {in_edge_i, out_edge_i};

    for (genvar g = 0; g < NUM_CPU_CH; g++) begin : g_cpu
        dma_cpu_req u_req (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .flag_i      (live_w[g]),
            .shadow_i    (shad_w[g]),
            .delay_en_i  (delay_en_i),
            .edge_mode_i (edge_w[g]),
            .req_o       (req_w[g])
        );
    end

    assign cpu_out_req_o = req_w[0];
    assign cpu_in_req_o  = req_w[1];

endmodule

// File: rtl/uart_dma_req_gen_chk.sv
module uart_dma_req_gen_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             dma_multi_i,
    input logic [CNT_W-1:0] rx_count_i,
    input logic             tx_empty_i,
    input logic             tx_full_i,
    input logic             p2h_full_i,
    input logic             p2h_full_shadow_i,
    input logic             h2p_empty_i,
    input logic             h2p_empty_shadow_i,
    input logic             delay_en_i,
    input logic             out_edge_i,
    input logic             in_edge_i,
    input logic             host_rx_req_o,
    input logic             host_tx_req_o,
    input logic             cpu_out_req_o,
    input logic             cpu_in_req_o
);

    AST_SINGLE_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dma_multi_i |=> host_rx_req_o == ($past(rx_count_i) != '0)); // R3

    AST_SINGLE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dma_multi_i |=> host_tx_req_o == $past(tx_empty_i)); // R4

    AST_MULTI_RX_EMPTY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_multi_i && rx_count_i == '0 |=> !host_rx_req_o); // R5

    AST_MULTI_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_multi_i && $past(dma_multi_i) && host_rx_req_o && rx_count_i != '0
        |=> host_rx_req_o); // R5

    AST_MULTI_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_multi_i |=> host_tx_req_o == !$past(tx_full_i)); // R6

    AST_OUT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_edge_i && !delay_en_i |=> cpu_out_req_o == !$past(p2h_full_i)); // R8

    AST_IN_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_edge_i && !delay_en_i |=> cpu_in_req_o == !$past(h2p_empty_i)); // R8

    AST_OUT_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_edge_i && delay_en_i |=> cpu_out_req_o == !$past(p2h_full_shadow_i)); // R9

    AST_IN_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_edge_i && delay_en_i |=> cpu_in_req_o == !$past(h2p_empty_shadow_i)); // R9

    AST_OUT_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_out_req_o && out_edge_i |=> !cpu_out_req_o); // R10

    AST_IN_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_in_req_o && in_edge_i |=> !cpu_in_req_o); // R10

endmodule

bind uart_dma_req_gen uart_dma_req_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .dma_multi_i        (dma_multi_i),
    .rx_count_i         (rx_count_i),
    .tx_empty_i         (tx_empty_i),
    .tx_full_i          (tx_full_i),
    .p2h_full_i         (p2h_full_i),
    .p2h_full_shadow_i  (p2h_full_shadow_i),
    .h2p_empty_i        (h2p_empty_i),
    .h2p_empty_shadow_i (h2p_empty_shadow_i),
    .delay_en_i         (delay_en_i),
    .out_edge_i         (out_edge_i),
    .in_edge_i          (in_edge_i),
    .host_rx_req_o      (host_rx_req_o),
    .host_tx_req_o      (host_tx_req_o),
    .cpu_out_req_o      (cpu_out_req_o),
    .cpu_in_req_o       (cpu_in_req_o)
);

// File: tb/tb_uart_dma_req_gen.sv
module tb_uart_dma_req_gen;

    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dma_multi = 1'b0;
    logic [1:0]       rx_trig = 2'b00;
    logic [CNT_W-1:0] rx_count = '0;
    logic             tx_empty = 1'b0;
    logic             tx_full = 1'b0;
    logic             p2h_full = 1'b1;
    logic             p2h_full_sh = 1'b1;
    logic             h2p_empty = 1'b1;
    logic             h2p_empty_sh = 1'b1;
    logic             dly_en = 1'b0;
    logic             out_edge = 1'b0;
    logic             in_edge = 1'b0;
    logic             host_rx_req, host_tx_req, cpu_out_req, cpu_in_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_dma_req_gen dut (
        .clk_i              (clk),
        .rst_ni             (rst_n),
        .dma_multi_i        (dma_multi),
        .rx_trig_i          (rx_trig),
        .rx_count_i         (rx_count),
        .tx_empty_i         (tx_empty),
        .tx_full_i          (tx_full),
        .p2h_full_i         (p2h_full),
        .p2h_full_shadow_i  (p2h_full_sh),
        .h2p_empty_i        (h2p_empty),
        .h2p_empty_shadow_i (h2p_empty_sh),
        .delay_en_i         (dly_en),
        .out_edge_i         (out_edge),
        .in_edge_i          (in_edge),
        .host_rx_req_o      (host_rx_req),
        .host_tx_req_o      (host_tx_req),
        .cpu_out_req_o      (cpu_out_req),
        .cpu_in_req_o       (cpu_in_req)
    );

    // Advance one clock; outputs are sampled and inputs driven 2 ns after the edge.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rx_count = 5'd3; tx_empty = 1'b1; p2h_full = 1'b0; h2p_empty = 1'b0;
        p2h_full_sh = 1'b0; h2p_empty_sh = 1'b0;
        tick(); tick();
        chk(host_rx_req, 1'b0, "R1 host_rx in reset");
        chk(host_tx_req, 1'b0, "R1 host_tx in reset");
        chk(cpu_out_req, 1'b0, "R1 cpu_out in reset");
        chk(cpu_in_req,  1'b0, "R1 cpu_in in reset");
        rx_count = '0; tx_empty = 1'b0; p2h_full = 1'b1; h2p_empty = 1'b1;
        p2h_full_sh = 1'b1; h2p_empty_sh = 1'b1;
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_single_rx();
        dma_multi = 1'b0; rx_trig = 2'b11;
        rx_count = 5'd0; tick();
        chk(host_rx_req, 1'b0, "R3 single count 0");
        rx_count = 5'd1;
        #1 chk(host_rx_req, 1'b0, "R11 no change before edge");
        tick();
        chk(host_rx_req, 1'b1, "R3 single count 1");
        rx_count = 5'd16; tick();
        chk(host_rx_req, 1'b1, "R3 single count 16");
        rx_count = 5'd0; tick();
        chk(host_rx_req, 1'b0, "R3 single back to 0");
    endtask

    task automatic t_single_tx();
        dma_multi = 1'b0; tx_full = 1'b0;
        tx_empty = 1'b1; tick();
        chk(host_tx_req, 1'b1, "R4 single tx empty");
        tx_empty = 1'b0; tick();
        chk(host_tx_req, 1'b0, "R4 single tx not empty");
    endtask

    task automatic t_multi_rx();
        dma_multi = 1'b1;
        for (int c = 0; c < 4; c++) begin
            int lv;
            lv = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
            rx_trig = 2'(c);
            rx_count = '0; tick();
            chk(host_rx_req, 1'b0, "R5 multi empty");
            rx_count = CNT_W'(lv - 1); tick();
            chk(host_rx_req, 1'b0, "R2 R5 below trigger");
            rx_count = CNT_W'(lv);
            #1 chk(host_rx_req, 1'b0, "R11 trigger not yet seen");
            tick();
            chk(host_rx_req, 1'b1, "R2 R5 at trigger");
            rx_count = 5'd1; tick();
            chk(host_rx_req, 1'b1, "R5 hold while nonempty");
            rx_count = 5'd0; tick();
            chk(host_rx_req, 1'b0, "R5 clear on empty");
        end
        rx_trig = 2'b01; rx_count = 5'd16; tick();
        chk(host_rx_req, 1'b1, "R5 above trigger");
        rx_count = '0; tick();
    endtask

    task automatic t_multi_tx();
        dma_multi = 1'b1; tx_empty = 1'b0;
        tx_full = 1'b0; tick();
        chk(host_tx_req, 1'b1, "R6 multi tx not full");
        tx_full = 1'b1; tick();
        chk(host_tx_req, 1'b0, "R6 multi tx full");
        tx_full = 1'b0; tx_empty = 1'b1; tick();
        chk(host_tx_req, 1'b1, "R6 multi tx empty");
        tx_empty = 1'b0;
    endtask

    task automatic t_mode_clear();
        dma_multi = 1'b1; rx_trig = 2'b11;
        rx_count = 5'd14; tick();
        chk(host_rx_req, 1'b1, "R7 set at 14");
        rx_count = 5'd3; tick();
        chk(host_rx_req, 1'b1, "R7 control hold at 3");
        dma_multi = 1'b0; tick();
        chk(host_rx_req, 1'b1, "R7 single mode count 3");
        dma_multi = 1'b1; tick();
        chk(host_rx_req, 1'b0, "R7 hold cleared by single");
        rx_count = '0; tick();
        dma_multi = 1'b0;
    endtask

    task automatic t_cpu_level();
        dly_en = 1'b0; out_edge = 1'b0; in_edge = 1'b0;
        p2h_full = 1'b0; p2h_full_sh = 1'b1;
        h2p_empty = 1'b1; h2p_empty_sh = 1'b0;
        tick();
        chk(cpu_out_req, 1'b1, "R8 out live not full");
        chk(cpu_in_req,  1'b0, "R8 in live empty");
        p2h_full = 1'b1; h2p_empty = 1'b0;
        p2h_full_sh = 1'b0; h2p_empty_sh = 1'b1;
        tick();
        chk(cpu_out_req, 1'b0, "R8 out live full");
        chk(cpu_in_req,  1'b1, "R8 in live not empty");
    endtask

    task automatic t_cpu_shadow();
        dly_en = 1'b1; out_edge = 1'b0; in_edge = 1'b0;
        p2h_full = 1'b0; p2h_full_sh = 1'b1;
        h2p_empty = 1'b1; h2p_empty_sh = 1'b0;
        tick();
        chk(cpu_out_req, 1'b0, "R9 out shadow full, live ignored");
        chk(cpu_in_req,  1'b1, "R9 in shadow not empty, live ignored");
        p2h_full_sh = 1'b0; h2p_empty_sh = 1'b1;
        tick();
        chk(cpu_out_req, 1'b1, "R9 out shadow not full");
        chk(cpu_in_req,  1'b0, "R9 in shadow empty");
        dly_en = 1'b0; p2h_full = 1'b1; h2p_empty = 1'b1;
        p2h_full_sh = 1'b1; h2p_empty_sh = 1'b1;
        tick();
    endtask

    task automatic t_cpu_edge();
        out_edge = 1'b1; in_edge = 1'b1; dly_en = 1'b0;
        p2h_full = 1'b1; h2p_empty = 1'b1; tick();
        chk(cpu_out_req, 1'b0, "R10 out idle");
        p2h_full = 1'b0; h2p_empty = 1'b0; tick();
        chk(cpu_out_req, 1'b1, "R10 out pulse");
        chk(cpu_in_req,  1'b1, "R10 in pulse");
        tick();
        chk(cpu_out_req, 1'b0, "R10 out pulse one cycle");
        chk(cpu_in_req,  1'b0, "R10 in pulse one cycle");
        tick();
        chk(cpu_out_req, 1'b0, "R10 out no repeat");
        p2h_full = 1'b1; tick();
        chk(cpu_out_req, 1'b0, "R10 out falling no pulse");
        p2h_full = 1'b0; tick();
        chk(cpu_out_req, 1'b1, "R10 out second pulse");
        out_edge = 1'b0; in_edge = 1'b0; p2h_full = 1'b1; h2p_empty = 1'b1;
        tick();
    endtask

    initial begin
        t_reset();
        t_single_rx();
        t_single_tx();
        t_multi_rx();
        t_multi_tx();
        t_mode_clear();
        t_cpu_level();
        t_cpu_shadow();
        t_cpu_edge();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule